// File: doc/BRIEF.md
# Lockable Extended Graphics Register Bank

This block holds a small set of extended graphics-controller registers behind an index/data port pair. A host picks a register by index and then reads or writes it through a synchronous strobe interface. There are seven registers, at indices 0x09 to 0x0F. They are two bank-offset registers, a memory-configuration register, a video-configuration register, a CRT-control register, a video-control register and a key register. The key register decides whether the other six can be reached.

The block drives its register contents out to the rest of the display subsystem. These outputs are the two bank offsets, the second-bank enable, and the top two bits (17:16) of the display-start and cursor-start addresses. The block also decodes a 2-bit dot-clock selection from the miscellaneous output register value that it receives. The installed memory size is a static configuration input that is captured while reset is held, and it is reported in the memory-configuration register.

Top module: `svga_ext_regs`

## Requirements
- R1: After reset, the outputs are as follows: rdData, bankA, bankB, dualBank, dispStartHi and cursorStartHi are all 0, index 0x0F reads 0x05, and indices 0x09, 0x0A, 0x0C, 0x0D and 0x0E read 0x00.
- R2: A read of an index outside 0x09..0x0F returns 0x00. A write to such an index changes no output and no register value.
- R3: The bank is unlocked exactly when bits 2:0 of index 0x0F equal 3'b101. Index 0x0F accepts writes and returns its full 8 bits on reads, whether the bank is locked or not.
- R4: While the bank is locked, writes to indices 0x09..0x0E are dropped and reads of those indices return 0x00.
- R5: At index 0x0B, the host can write only bit 3. Bits 7:6 report the memCfg input as it was sampled during reset (01 = 256 KB, 10 = 512 KB, 11 = 1 MB), and all other bits read 0.
- R6: bankA and bankB output the full 8-bit contents of indices 0x09 and 0x0A. dualBank outputs bit 3 of index 0x0B.
- R7: Bits 4:3 of index 0x0D drive both dispStartHi and cursorStartHi, which are address bits 17:16.
- R8: clkSel equals bits 3:2 of the miscOut input, with no clock delay.
- R9: rdData is registered. It shows the selected register's value in the clock after the cycle in which rdStb is high, and it holds its value in cycles without rdStb.
- R10: Indices 0x0C, 0x0D and 0x0E store all 8 written bits and return them on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| memCfg | input | 2 | Static installed-memory code, sampled during reset |
| regIndex | input | 8 | Register index |
| wrData | input | 8 | Write data |
| wrStb | input | 1 | Write strobe |
| rdStb | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| miscOut | input | 8 | Miscellaneous output register value |
| bankA | output | 8 | First bank offset |
| bankB | output | 8 | Second bank offset |
| dualBank | output | 1 | Second-bank enable |
| dispStartHi | output | 2 | Display start address bits 17:16 |
| cursorStartHi | output | 2 | Cursor start address bits 17:16 |
| clkSel | output | 2 | Dot-clock select |

## Verification
The hardest state to reach from the ports is a locked bank whose key register holds a value other than 0x00 and 0x05. In that state a write to the key register must still be accepted, and it must unlock the bank only through bits 2:0, for example with 0x0D or 0xFD. The random stimulus writes arbitrary bytes to index 0x0F about one time in six, and writes exactly 0x05 in a further share of operations. This makes the bank move between locked and unlocked states with many different key values, while writes and reads to protected indices fall on both sides of each change. Directed steps add a second reset with a different memory code and a check that read data is held.

// File: rtl/svga_ext_pkg.sv
package svga_ext_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W = 8;
  localparam int PLAIN_N = 5;
  localparam int SEL_W = 3;
  localparam int MEM_W = 2;
  localparam int CLK_SEL_LSB = 2;
  localparam int CLK_SEL_W = 2;
  localparam int DUAL_BIT = 3;
  localparam int HI_LSB = 3;

  localparam logic [IDX_W-1:0] IDX_FIRST = 8'h09;
  localparam logic [IDX_W-1:0] IDX_MEM = 8'h0B;
  localparam logic [IDX_W-1:0] IDX_KEY = 8'h0F;
  localparam logic [2:0] UNLOCK_KEY = 3'b101;
  localparam logic [DATA_W-1:0] KEY_RESET = 8'h05;

  // indices of the fully writable registers, slot order
  localparam logic [IDX_W-1:0] PLAIN_IDX [PLAIN_N] = '{8'h09, 8'h0A, 8'h0C, 8'h0D, 8'h0E};
  localparam int SLOT_BANK_A = 0;
  localparam int SLOT_BANK_B = 1;
  localparam int SLOT_CRT = 3;

  typedef struct packed {
    logic [PLAIN_N-1:0] wrPlain;
    logic wrDual;
    logic wrKey;
    logic rdEn;
    logic [SEL_W-1:0] rdSel;
  } strobe_t;
endpackage

// File: rtl/svga_ext_ctrl.sv
module svga_ext_ctrl
  import svga_ext_pkg::*;
(
  input  logic [IDX_W-1:0] regIndex,
  input  logic             wrStb,
  input  logic             rdStb,
  input  logic [2:0]       keyLow,
  output logic             unlocked,
  output strobe_t          stb
);
  logic inRange;
  logic isKey;
  logic accessOk;

  always_comb begin
    unlocked = (keyLow == UNLOCK_KEY);
    inRange  = (regIndex >= IDX_FIRST) && (regIndex <= IDX_KEY);
    isKey    = (regIndex == IDX_KEY);
    accessOk = isKey || (inRange && unlocked);
  end

  for (genvar k = 0; k < PLAIN_N; k++) begin : g_plainStb
    assign stb.wrPlain[k] = wrStb && unlocked && (regIndex == PLAIN_IDX[k]);
  end

  assign stb.wrDual = wrStb && unlocked && (regIndex == IDX_MEM);
  assign stb.wrKey  = wrStb && isKey;
  assign stb.rdEn   = rdStb;
  // indices 0x09..0x0F have distinct nonzero low bits; zero selects 0x00
  assign stb.rdSel  = accessOk ? regIndex[SEL_W-1:0] : '0;
endmodule

// File: rtl/svga_ext_dp.sv
module svga_ext_dp
  import svga_ext_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MEM_W-1:0]  memCfg,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           stb,
  output logic [2:0]        keyLow,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] bankA,
  output logic [DATA_W-1:0] bankB,
  output logic              dualBank,
  output logic [1:0]        crtHi
);
  logic [DATA_W-1:0] plainQ [PLAIN_N];
  logic              dualQ;
  logic [DATA_W-1:0] keyQ;
  logic [MEM_W-1:0]  memSizeQ;
  logic [DATA_W-1:0] memView;
  logic [DATA_W-1:0] rdMux;

  for (genvar k = 0; k < PLAIN_N; k++) begin : g_plain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) plainQ[k] <= '0;
      else if (stb.wrPlain[k]) plainQ[k] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dualQ <= 1'b0;
      keyQ  <= KEY_RESET;
    end else begin
      if (stb.wrDual) dualQ <= wrData[DUAL_BIT];
      if (stb.wrKey)  keyQ  <= wrData;
    end
  end

  // installed size is sampled on clock edges while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) memSizeQ <= memCfg;
  end

  always_comb begin
    memView = '0;
    memView[DATA_W-1 -: MEM_W] = memSizeQ;
    memView[DUAL_BIT] = dualQ;
  end

  always_comb begin
    case (stb.rdSel)
      3'd1:    rdMux = plainQ[0];
      3'd2:    rdMux = plainQ[1];
      3'd3:    rdMux = memView;
      3'd4:    rdMux = plainQ[2];
      3'd5:    rdMux = plainQ[3];
      3'd6:    rdMux = plainQ[4];
      3'd7:    rdMux = keyQ;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (stb.rdEn) rdData <= rdMux;
  end

  assign keyLow   = keyQ[2:0];
  assign bankA    = plainQ[SLOT_BANK_A];
  assign bankB    = plainQ[SLOT_BANK_B];
  assign dualBank = dualQ;
  assign crtHi    = plainQ[SLOT_CRT][HI_LSB +: 2];
endmodule

// File: rtl/svga_ext_regs.sv
module svga_ext_regs
  import svga_ext_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MEM_W-1:0]     memCfg,
  input  logic [IDX_W-1:0]     regIndex,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 wrStb,
  input  logic                 rdStb,
  output logic [DATA_W-1:0]    rdData,
  input  logic [DATA_W-1:0]    miscOut,
  output logic [DATA_W-1:0]    bankA,
  output logic [DATA_W-1:0]    bankB,
  output logic                 dualBank,
  output logic [1:0]           dispStartHi,
  output logic [1:0]           cursorStartHi,
  output logic [CLK_SEL_W-1:0] clkSel
);
  strobe_t    stb;
  logic [2:0] keyLow;
  logic       unlocked;
  logic [1:0] crtHi;

  svga_ext_ctrl u_ctrl (
    .regIndex(regIndex),
    .wrStb(wrStb),
    .rdStb(rdStb),
    .keyLow(keyLow),
    .unlocked(unlocked),
    .stb(stb)
  );

  svga_ext_dp u_dp (
    .clk(clk),
    .rstN(rstN),
    .memCfg(memCfg),
    .wrData(wrData),
    .stb(stb),
    .keyLow(keyLow),
    .rdData(rdData),
    .bankA(bankA),
    .bankB(bankB),
    .dualBank(dualBank),
    .crtHi(crtHi)
  );

  assign dispStartHi   = crtHi;
  assign cursorStartHi = crtHi;
  assign clkSel        = miscOut[CLK_SEL_LSB +: CLK_SEL_W];
endmodule

// File: rtl/svga_ext_chk.sv
module svga_ext_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regIndex,
  input logic       wrStb,
  input logic       rdStb,
  input logic [7:0] rdData,
  input logic [7:0] bankA,
  input logic [7:0] bankB,
  input logic       dualBank,
  input logic [1:0] dispStartHi,
  input logic [1:0] cursorStartHi,
  input logic       unlocked
);
  logic outRange;
  logic protIdx;
  assign outRange = (regIndex < 8'h09) || (regIndex > 8'h0F);
  assign protIdx  = (regIndex >= 8'h09) && (regIndex <= 8'h0E);

  // R2
  out_of_range_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && outRange) |=> ($stable(bankA) && $stable(bankB) && $stable(dualBank) && $stable(dispStartHi)));

  // R4
  locked_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && protIdx && !unlocked) |=> (rdData == 8'h00));

  // R4
  locked_write_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && protIdx && !unlocked) |=> ($stable(bankA) && $stable(bankB) && $stable(dualBank) && $stable(dispStartHi)));

  // R6
  bank_a_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStb && regIndex == 8'h09) |=> $stable(bankA));

  // R7
  start_hi_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispStartHi == cursorStartHi);

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> $stable(rdData));
endmodule

bind svga_ext_regs svga_ext_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .regIndex(regIndex),
  .wrStb(wrStb),
  .rdStb(rdStb),
  .rdData(rdData),
  .bankA(bankA),
  .bankB(bankB),
  .dualBank(dualBank),
  .dispStartHi(dispStartHi),
  .cursorStartHi(cursorStartHi),
  .unlocked(unlocked)
);

// File: tb/svga_ext_regs_test.sv
module svga_ext_regs_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] memCfg = 2'b10;
  logic [7:0] regIndex = '0;
  logic [7:0] wrData = '0;
  logic       wrStb = 1'b0;
  logic       rdStb = 1'b0;
  logic [7:0] rdData;
  logic [7:0] miscOut = '0;
  logic [7:0] bankA, bankB;
  logic       dualBank;
  logic [1:0] dispStartHi, cursorStartHi, clkSel;

  int errors = 0;
  int checks = 0;

  // bench model
  logic [7:0] mdl [16];
  logic       mdlDual;
  logic [1:0] mdlMem;

  svga_ext_regs uut (
    .clk(clk), .rstN(rstN), .memCfg(memCfg), .regIndex(regIndex),
    .wrData(wrData), .wrStb(wrStb), .rdStb(rdStb), .rdData(rdData),
    .miscOut(miscOut), .bankA(bankA), .bankB(bankB), .dualBank(dualBank),
    .dispStartHi(dispStartHi), .cursorStartHi(cursorStartHi), .clkSel(clkSel)
  );

  always #10 clk = ~clk;

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic mdlUnlocked();
    return mdl[15][2:0] == 3'b101;
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] idx);
    if (idx == 8'h0F) return mdl[15];
    if (idx < 8'h09 || idx > 8'h0E) return 8'h00;
    if (!mdlUnlocked()) return 8'h00;
    if (idx == 8'h0B) return {mdlMem, 2'b00, mdlDual, 3'b000};
    return mdl[idx[3:0]];
  endfunction

  task automatic mdlReset(input logic [1:0] mem);
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    mdl[15] = 8'h05;
    mdlDual = 1'b0;
    mdlMem = mem;
  endtask

  task automatic mdlWrite(input logic [7:0] idx, input logic [7:0] d);
    if (idx == 8'h0F) mdl[15] = d;
    else if (idx >= 8'h09 && idx <= 8'h0E && mdlUnlocked()) begin
      if (idx == 8'h0B) mdlDual = d[3];
      else mdl[idx[3:0]] = d;
    end
  endtask

  task automatic doReset(input logic [1:0] mem);
    @(negedge clk);
    rstN = 1'b0;
    memCfg = mem;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mdlReset(mem);
  endtask

  task automatic doWrite(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    regIndex = idx; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
    mdlWrite(idx, d);
  endtask

  task automatic doRead(input logic [7:0] idx, output logic [7:0] v);
    @(negedge clk);
    regIndex = idx; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    v = rdData;
  endtask

  task automatic checkRead(input string req, input logic [7:0] idx);
    logic [7:0] v;
    doRead(idx, v);
    check(req, v, expRead(idx));
  endtask

  task automatic checkOutputs(input string req);
    check({req, " bankA"}, bankA, mdl[9]);
    check({req, " bankB"}, bankB, mdl[10]);
    check({req, " dualBank"}, {7'd0, dualBank}, {7'd0, mdlDual});
    check({req, " dispStartHi"}, {6'd0, dispStartHi}, {6'd0, mdl[13][4:3]});
    check({req, " cursorStartHi"}, {6'd0, cursorStartHi}, {6'd0, mdl[13][4:3]});
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] held;
    void'($urandom(32'd20240611));
    doReset(2'b10);

    // R1 reset state
    @(negedge clk);
    check("R1 rdData", rdData, 8'h00);
    checkOutputs("R1");
    checkRead("R1 key", 8'h0F);
    check("R1 key value", expRead(8'h0F), 8'h05);
    checkRead("R1 idx09", 8'h09);
    checkRead("R1 idx0C", 8'h0C);
    checkRead("R1 idx0E", 8'h0E);

    // R5 memory code and write mask
    checkRead("R5 idx0B", 8'h0B);
    doWrite(8'h0B, 8'hFF);
    checkRead("R5 masked write", 8'h0B);
    checkOutputs("R6 dual set");
    doWrite(8'h0B, 8'hF7);
    checkRead("R5 clear bit3", 8'h0B);

    // R6 / R7 / R10
    doWrite(8'h09, 8'hA5);
    doWrite(8'h0A, 8'h3C);
    doWrite(8'h0D, 8'h18);
    checkOutputs("R6 R7");
    doWrite(8'h0D, 8'h08);
    checkOutputs("R7 bit3 only");
    doWrite(8'h0C, 8'h5A);
    doWrite(8'h0E, 8'hC3);
    checkRead("R10 idx0C", 8'h0C);
    checkRead("R10 idx0D", 8'h0D);
    checkRead("R10 idx0E", 8'h0E);

    // R2 out-of-range indices
    doWrite(8'h08, 8'hFF);
    doWrite(8'h10, 8'hFF);
    doWrite(8'h19, 8'hFF);
    checkOutputs("R2 write ignored");
    checkRead("R2 idx08", 8'h08);
    checkRead("R2 idx00", 8'h00);
    checkRead("R2 idx1F", 8'h1F);
    checkRead("R2 idx09 after", 8'h09);

    // R3 / R4 lock behaviour
    doWrite(8'h0F, 8'h06);
    checkRead("R3 key readback", 8'h0F);
    checkRead("R4 locked read", 8'h09);
    checkRead("R4 locked read 0B", 8'h0B);
    doWrite(8'h09, 8'h11);
    doWrite(8'h0D, 8'h00);
    doWrite(8'h0B, 8'h00);
    checkOutputs("R4 locked write");
    doWrite(8'h0F, 8'hFD);
    checkRead("R3 unlock by low bits", 8'h0F);
    checkRead("R3 unlocked read", 8'h09);
    doWrite(8'h0F, 8'h00);
    checkRead("R4 locked after 00", 8'h0A);
    doWrite(8'h0F, 8'h05);
    checkRead("R3 unlocked again", 8'h0A);

    // R8 clock select
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      miscOut = 8'($urandom);
      #1;
      check("R8 clkSel", {6'd0, clkSel}, {6'd0, miscOut[3:2]});
    end

    // R9 read data held without strobe
    doRead(8'h0E, held);
    doWrite(8'h0E, 8'h77);
    repeat (3) @(negedge clk);
    check("R9 held", rdData, held);
    checkRead("R9 new value", 8'h0E);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [7:0] idx;
      logic [7:0] d;
      op = int'($urandom_range(0, 11));
      idx = (($urandom_range(0, 3)) == 0) ? 8'($urandom) : 8'(8'h07 + $urandom_range(0, 10));
      d = 8'($urandom);
      if (op < 2) doWrite(8'h0F, d);
      else if (op == 2) doWrite(8'h0F, 8'h05);
      else if (op < 7) doWrite(idx, d);
      else begin
        doRead(idx, v);
        check("R2 R3 R4 R5 R10 random read", v, expRead(idx));
      end
      if (n % 25 == 0) checkOutputs("R6 R7 random");
    end

    // R1 R5 second reset with different memory code
    doReset(2'b11);
    @(negedge clk);
    checkOutputs("R1 second reset");
    checkRead("R5 mem 1MB", 8'h0B);
    check("R5 mem code", expRead(8'h0B), 8'hC0);
    doReset(2'b01);
    checkRead("R5 mem 256KB", 8'h0B);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule